// File: doc/BRIEF.md
# Data Address Translation Lookup with Access Checking

This block translates a virtual data address through a fully associative table of 64 translation entries. Each entry holds a virtual page number, a physical page number, an address-space tag, a global flag that makes the entry match any tag, a page-size code, a two-bit protection field, a modified (dirty) flag and a valid flag. One request compares the address against every entry at the same time. The result is the physical address, or a fault code for any of these cases: no matching entry, more than one matching entry, an access that the privilege level does not permit, or a first write to a clean page.

Entries are written through a load port. The load port takes the entry index and all fields of the entry in one cycle. The block also keeps a six-bit victim pointer. The pointer moves forward on each lookup, and a software-set upper bound can limit its range. Software reads the pointer to choose the slot for the next load. The response appears one cycle after the request. On every fault, the virtual address that faulted is stored in a register that software can read.

Top module: `dtlb_check`

## Requirements
- R1: An entry hits only when it is valid and the address lies inside its page. Its tag must also equal the request tag, unless the entry is global or tag checking is off. With no hit, the fault code is 0x040 for a read and 0x060 for a write, and `rsp_ok` is 0.
- R2: Tag checking is off only when the single-address-space input is 1 and the privileged input is 1. In every other case it is on.
- R3: The size code gives the page size: 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. Page numbers are counted in 1 KB units. The page-number bits that fall below the page size are ignored when comparing. The physical address is built from the upper physical page bits and the in-page offset of the request, which passes through unchanged.
- R4: When two or more entries hit, the fault code is 0x140.
- R5: The protection index is {prot[1:0], privileged}. Index 0 or 2 permits no access. Index 1, 4 or 5 permits reads only. Index 3, 6 or 7 permits reads and writes. A denied read gives 0x0A0 and a denied write gives 0x0C0.
- R6: A permitted write to an entry whose dirty flag is 0 gives 0x080. A permitted access with no fault gives `rsp_ok` = 1, fault code 0 and the translated address.
- R7: The victim pointer adds one on each lookup. It returns to 0 when the incremented value is above a nonzero bound `urb_lim`, or above 63. It does not change on cycles with no lookup.
- R8: `rsp_valid` and the result appear in the cycle after the request and last exactly one cycle.
- R9: Each fault stores the request address in `fault_addr`. The value stays unchanged through lookups that succeed.
- R10: After reset, all entries are invalid, the victim pointer is 0, and all response outputs and `fault_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one entry |
| ld_idx | input | 6 | Entry index to write |
| ld_valid | input | 1 | Valid flag of the new entry |
| ld_global | input | 1 | Match any tag |
| ld_asid | input | 8 | Address-space tag |
| ld_vpn | input | 22 | Virtual page number, 1 KB units |
| ld_ppn | input | 22 | Physical page number, 1 KB units |
| ld_size | input | 2 | Page size code |
| ld_prot | input | 2 | Protection field |
| ld_dirty | input | 1 | Page already written |
| urb_lim | input | 6 | Victim pointer bound, 0 = full range |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Privileged mode |
| req_single | input | 1 | Single-address-space mode |
| req_asid | input | 8 | Current address-space tag |
| rsp_valid | output | 1 | Result present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_exc | output | 12 | Fault code, 0 on success |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| fault_addr | output | 32 | Last faulting virtual address |
| urc_o | output | 6 | Victim pointer |

## Verification
A request gives its result one clock edge later. The bench drives each request at a falling edge, drops `req_valid` at the next falling edge, and reads the outputs at that same point, one rising edge after the request. The victim pointer and `fault_addr` change on the same edge as the result, so they are checked at that same sampling point. An entry load takes effect on the edge after it is driven. Every load is finished before the first lookup that depends on it. In one idle cycle the bench confirms that `rsp_valid` has dropped back to 0.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int PAGE_SHIFT = 10;
    localparam int EXC_W      = 12;

    localparam logic [EXC_W-1:0] EXC_NONE      = 12'h000;
    localparam logic [EXC_W-1:0] EXC_MISS_RD   = 12'h040;
    localparam logic [EXC_W-1:0] EXC_MISS_WR   = 12'h060;
    localparam logic [EXC_W-1:0] EXC_FIRST_WR  = 12'h080;
    localparam logic [EXC_W-1:0] EXC_PROT_RD   = 12'h0A0;
    localparam logic [EXC_W-1:0] EXC_PROT_WR   = 12'h0C0;
    localparam logic [EXC_W-1:0] EXC_MULTI     = 12'h140;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RO   = 2'd1,
        ACC_RW   = 2'd2
    } acc_class_e;

    // page-number bits below the page size, in 1 KB units
    function automatic int unsigned page_low_bits(input logic [1:0] size);
        case (size)
            2'd0:    return 0;
            2'd1:    return 2;
            2'd2:    return 6;
            default: return 10;
        endcase
    endfunction

    function automatic acc_class_e access_class(input logic [1:0] prot, input logic priv);
        case ({prot, priv})
            3'd0, 3'd2:       return ACC_NONE;
            3'd1, 3'd4, 3'd5: return ACC_RO;
            default:          return ACC_RW;
        endcase
    endfunction

endpackage

// File: rtl/dtlb_way_match.sv
module dtlb_way_match #(
    parameter int VPN_W  = 22,
    parameter int ASID_W = 8
) (
    input  logic              ent_valid,
    input  logic              ent_global,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]  ent_vpn,
    input  logic [1:0]        ent_size,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              asid_chk,
    output logic              hit
);
    logic [VPN_W-1:0] keep_mask;
    logic             page_eq;
    logic             tag_ok;

    always_comb begin
        keep_mask = {VPN_W{1'b1}} << dtlb_pkg::page_low_bits(ent_size);
        page_eq   = ((ent_vpn ^ req_vpn) & keep_mask) == '0;
        tag_ok    = ent_global || !asid_chk || (ent_asid == req_asid);
        hit       = ent_valid && page_eq && tag_ok;
    end
endmodule

// File: rtl/dtlb_access.sv
module dtlb_access (
    input  logic [1:0] prot,
    input  logic       priv,
    input  logic       write,
    input  logic       dirty,
    output logic       denied,
    output logic       clean_write
);
    import dtlb_pkg::*;

    acc_class_e cls;

    always_comb begin
        cls         = access_class(prot, priv);
        denied      = (cls == ACC_NONE) || (cls == ACC_RO && write);
        clean_write = !denied && write && !dirty;
    end
endmodule

// File: rtl/dtlb_urc.sv
module dtlb_urc #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [IDX_W-1:0] bound,
    output logic [IDX_W-1:0] urc
);
    logic [IDX_W-1:0] urc_d, urc_q;
    logic [IDX_W:0]   inc;

    always_comb begin
        inc   = {1'b0, urc_q} + 1'b1;
        urc_d = urc_q;
        if (step) begin
            if ((bound != '0 && inc > {1'b0, bound}) || inc > (IDX_W + 1)'(ENTRIES - 1))
                urc_d = '0;
            else
                urc_d = inc[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) urc_q <= '0;
        else        urc_q <= urc_d;
    end

    assign urc = urc_q;

    AST_URC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (urc_q == '0) || (urc_q == $past(urc_q) + 1'b1)); // R7
    AST_URC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(urc_q)); // R7
endmodule

// File: rtl/dtlb_check.sv
module dtlb_check #(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VPN_W  = ADDR_W - dtlb_pkg::PAGE_SHIFT,
    localparam int EXC_W  = dtlb_pkg::EXC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic              ld_valid,
    input  logic              ld_global,
    input  logic [ASID_W-1:0] ld_asid,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic [VPN_W-1:0]  ld_ppn,
    input  logic [1:0]        ld_size,
    input  logic [1:0]        ld_prot,
    input  logic              ld_dirty,
    input  logic [IDX_W-1:0]  urb_lim,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic              req_single,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [EXC_W-1:0]  rsp_exc,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [IDX_W-1:0]  urc_o
);
    import dtlb_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [1:0]        size;
        logic [1:0]        prot;
        logic              dirty;
    } entry_t;

    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_ok;
        logic [EXC_W-1:0]  exc;
        logic [ADDR_W-1:0] paddr;
        logic [ADDR_W-1:0] fault;
    } state_t;

    entry_t           tbl_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [VPN_W-1:0] req_vpn;
    logic             asid_chk;

    assign req_vpn  = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign asid_chk = !(req_single && req_priv);

    // entry storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else if (ld_en) begin
            tbl_q[ld_idx] <= '{valid: ld_valid, glob: ld_global, asid: ld_asid,
                               vpn: ld_vpn, ppn: ld_ppn, size: ld_size,
                               prot: ld_prot, dirty: ld_dirty};
        end
    end

    // parallel comparators
    for (genvar g = 0; g < ENTRIES; g++) begin : g_way
        dtlb_way_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
            .ent_valid (tbl_q[g].valid),
            .ent_global(tbl_q[g].glob),
            .ent_asid  (tbl_q[g].asid),
            .ent_vpn   (tbl_q[g].vpn),
            .ent_size  (tbl_q[g].size),
            .req_vpn   (req_vpn),
            .req_asid  (req_asid),
            .asid_chk  (asid_chk),
            .hit       (hit_vec[g])
        );
    end

    // one-hot select of the hitting entry
    entry_t sel;
    always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (hit_vec[i]) sel = sel | tbl_q[i];
    end

    logic denied, clean_write;
    dtlb_access u_access (
        .prot       (sel.prot),
        .priv       (req_priv),
        .write      (req_write),
        .dirty      (sel.dirty),
        .denied     (denied),
        .clean_write(clean_write)
    );

    dtlb_urc #(.ENTRIES(ENTRIES)) u_urc (
        .clk  (clk),
        .rst_n(rst_n),
        .step (req_valid),
        .bound(urb_lim),
        .urc  (urc_o)
    );

    state_t st_d, st_q;
    logic             any_hit, multi_hit;
    logic [VPN_W-1:0] page_keep;
    logic [EXC_W-1:0] exc_sel;

    always_comb begin
        any_hit   = |hit_vec;
        multi_hit = |(hit_vec & (hit_vec - 1'b1));
        page_keep = {VPN_W{1'b1}} << page_low_bits(sel.size);

        if (multi_hit)        exc_sel = EXC_MULTI;
        else if (!any_hit)    exc_sel = req_write ? EXC_MISS_WR : EXC_MISS_RD;
        else if (denied)      exc_sel = req_write ? EXC_PROT_WR : EXC_PROT_RD;
        else if (clean_write) exc_sel = EXC_FIRST_WR;
        else                  exc_sel = EXC_NONE;

        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        if (req_valid) begin
            st_d.exc    = exc_sel;
            st_d.rsp_ok = (exc_sel == EXC_NONE);
            if (exc_sel == EXC_NONE) begin
                st_d.paddr = {(sel.ppn & page_keep) | (req_vpn & ~page_keep),
                              req_addr[PAGE_SHIFT-1:0]};
            end else begin
                st_d.paddr = '0;
                st_d.fault = req_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_ok     = st_q.rsp_ok;
    assign rsp_exc    = st_q.exc;
    assign rsp_paddr  = st_q.paddr;
    assign fault_addr = st_q.fault;

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8
    AST_RSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R8
    AST_MULTI_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $countones(hit_vec) > 1) |=> (rsp_exc == EXC_MULTI && !rsp_ok)); // R4
    AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $countones(hit_vec) == 0) |=> (fault_addr == $past(req_addr))); // R9
    AST_OK_HOLDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> $stable(fault_addr)); // R9
endmodule

// File: tb/dtlb_check_tb.sv
module dtlb_check_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ld_en = 0;
    logic [5:0]  ld_idx = 0;
    logic        ld_valid = 0, ld_global = 0, ld_dirty = 0;
    logic [7:0]  ld_asid = 0;
    logic [21:0] ld_vpn = 0, ld_ppn = 0;
    logic [1:0]  ld_size = 0, ld_prot = 0;
    logic [5:0]  urb_lim = 0;
    logic        req_valid = 0, req_write = 0, req_priv = 0, req_single = 0;
    logic [31:0] req_addr = 0;
    logic [7:0]  req_asid = 0;
    logic        rsp_valid, rsp_ok;
    logic [11:0] rsp_exc;
    logic [31:0] rsp_paddr, fault_addr;
    logic [5:0]  urc_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [5:0]  urc_exp = 0;
    logic [31:0] fault_exp = 0;

    always #4 clk = ~clk;

    dtlb_check u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_valid(ld_valid), .ld_global(ld_global), .ld_asid(ld_asid),
        .ld_vpn(ld_vpn), .ld_ppn(ld_ppn), .ld_size(ld_size), .ld_prot(ld_prot),
        .ld_dirty(ld_dirty), .urb_lim(urb_lim), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_priv(req_priv),
        .req_single(req_single), .req_asid(req_asid), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_exc(rsp_exc), .rsp_paddr(rsp_paddr),
        .fault_addr(fault_addr), .urc_o(urc_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired (actual hang, expected completion)");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic v, input logic g, input logic [7:0] asid,
                        input logic [21:0] vpn, input logic [21:0] ppn, input logic [1:0] sz,
                        input logic [1:0] pr, input logic d);
        @(negedge clk);
        ld_en = 1; ld_idx = 6'(idx); ld_valid = v; ld_global = g; ld_asid = asid;
        ld_vpn = vpn; ld_ppn = ppn; ld_size = sz; ld_prot = pr; ld_dirty = d;
        @(negedge clk);
        ld_en = 0;
    endtask

    function automatic logic [5:0] urc_next(input logic [5:0] cur, input logic [5:0] bnd);
        int n = int'(cur) + 1;
        if ((bnd != 0 && n > int'(bnd)) || n > 63) return 6'd0;
        return 6'(n);
    endfunction

    // drive one request; outputs are read one rising edge later
    task automatic lookup(input logic [31:0] a, input logic w, input logic md,
                          input logic sv, input logic [7:0] asid);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = w; req_priv = md;
        req_single = sv; req_asid = asid;
        @(negedge clk);
        req_valid = 0;
        urc_exp = urc_next(urc_exp, urb_lim);
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        md;
        logic        sv;
        logic [7:0]  asid;
        logic        ok;
        logic [11:0] exc;
        logic [31:0] pa;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0404, 0, 0, 0, 8'h05, 1, 12'h000, 32'h0004_0004, 4'd1},  // R1 hit 1 KB
        '{32'h0000_07FC, 1, 0, 0, 8'h05, 1, 12'h000, 32'h0004_03FC, 4'd3},  // R3 top of 1 KB page
        '{32'h0000_0404, 0, 0, 0, 8'h06, 0, 12'h040, 32'h0,         4'd1},  // R1 tag mismatch read
        '{32'h0000_0404, 1, 0, 0, 8'h06, 0, 12'h060, 32'h0,         4'd1},  // R1 tag mismatch write
        '{32'h0000_0404, 0, 1, 1, 8'h06, 1, 12'h000, 32'h0004_0004, 4'd2},  // R2 check off
        '{32'h0000_0404, 0, 1, 0, 8'h06, 0, 12'h040, 32'h0,         4'd2},  // R2 priv, single off
        '{32'h0000_0404, 0, 0, 1, 8'h06, 0, 12'h040, 32'h0,         4'd2},  // R2 user, single on
        '{32'h0001_0ABC, 0, 0, 0, 8'h07, 0, 12'h0A0, 32'h0,         4'd5},  // R5 index 2
        '{32'h0001_0ABC, 1, 1, 0, 8'h07, 0, 12'h080, 32'h0,         4'd6},  // R6 clean write
        '{32'h0001_0ABC, 0, 1, 0, 8'h07, 1, 12'h000, 32'h0008_0ABC, 4'd3},  // R3 4 KB
        '{32'h0001_1000, 0, 1, 0, 8'h07, 0, 12'h040, 32'h0,         4'd3},  // R3 past 4 KB end
        '{32'h0040_FFFF, 0, 0, 0, 8'h22, 1, 12'h000, 32'h0080_FFFF, 4'd3},  // R3 64 KB global
        '{32'h0040_1234, 1, 0, 0, 8'h22, 0, 12'h0C0, 32'h0,         4'd5},  // R5 index 4 write
        '{32'h0040_1234, 1, 1, 0, 8'h22, 0, 12'h0C0, 32'h0,         4'd5},  // R5 index 5 write
        '{32'h0041_0000, 0, 0, 0, 8'h22, 0, 12'h040, 32'h0,         4'd3},  // R3 past 64 KB end
        '{32'h010F_FFF0, 0, 0, 0, 8'h03, 1, 12'h000, 32'h020F_FFF0, 4'd3},  // R3 1 MB
        '{32'h0100_0010, 1, 0, 0, 8'h03, 0, 12'h080, 32'h0,         4'd6},  // R6 clean 1 MB
        '{32'h0020_0010, 0, 0, 0, 8'h01, 0, 12'h140, 32'h0,         4'd4},  // R4 two hits
        '{32'h0020_0810, 0, 0, 0, 8'h01, 1, 12'h000, 32'h000C_0810, 4'd4},  // R4 single hit
        '{32'h0030_0000, 1, 0, 0, 8'h00, 0, 12'h060, 32'h0,         4'd1},  // R1 invalid entry
        '{32'h0050_0008, 0, 1, 0, 8'h02, 1, 12'h000, 32'h0014_0008, 4'd5},  // R5 index 1 read
        '{32'h0050_0008, 0, 0, 0, 8'h02, 0, 12'h0A0, 32'h0,         4'd5},  // R5 index 0
        '{32'h0050_0008, 1, 1, 0, 8'h02, 0, 12'h0C0, 32'h0,         4'd5},  // R5 index 1 write
        '{32'h0000_0404, 1, 0, 0, 8'h05, 1, 12'h000, 32'h0004_0004, 4'd6}   // R6 dirty write ok
    };

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "rsp_valid", 32'(rsp_valid), 0);
        chk("R10", "rsp_ok", 32'(rsp_ok), 0);
        chk("R10", "rsp_exc", 32'(rsp_exc), 0);
        chk("R10", "fault_addr", fault_addr, 0);
        chk("R10", "urc", 32'(urc_o), 0);
        rst_n = 1;

        // R10 entries start invalid: lookup misses
        lookup(32'h0000_0404, 0, 0, 0, 8'h05);
        fault_exp = 32'h0000_0404;
        chk("R10", "exc after reset", 32'(rsp_exc), 32'h040);
        chk("R8", "rsp_valid", 32'(rsp_valid), 1);
        @(negedge clk);
        chk("R8", "rsp_valid idle", 32'(rsp_valid), 0);

        load(0, 1, 0, 8'h05, 22'h000001, 22'h000100, 2'd0, 2'd3, 1);
        load(1, 1, 0, 8'h07, 22'h000040, 22'h000200, 2'd1, 2'd1, 0);
        load(2, 1, 1, 8'h09, 22'h00103F, 22'h002000, 2'd2, 2'd2, 1);
        load(3, 1, 0, 8'h03, 22'h004000, 22'h0080FF, 2'd3, 2'd3, 0);
        load(4, 1, 0, 8'h01, 22'h000800, 22'h000700, 2'd0, 2'd3, 1);
        load(5, 1, 0, 8'h01, 22'h000800, 22'h000300, 2'd1, 2'd3, 1);
        load(6, 0, 0, 8'h00, 22'h000C00, 22'h000C00, 2'd0, 2'd3, 1);
        load(7, 1, 0, 8'h02, 22'h001400, 22'h000500, 2'd0, 2'd0, 1);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].rq);
            lookup(VECS[i].addr, VECS[i].wr, VECS[i].md, VECS[i].sv, VECS[i].asid);
            if (!VECS[i].ok) fault_exp = VECS[i].addr;
            chk(tag, "rsp_ok", 32'(rsp_ok), 32'(VECS[i].ok));
            chk(tag, "rsp_exc", 32'(rsp_exc), 32'(VECS[i].exc));
            if (VECS[i].ok) chk(tag, "rsp_paddr", rsp_paddr, VECS[i].pa);
            chk("R9", "fault_addr", fault_addr, fault_exp);
            chk("R7", "urc", 32'(urc_o), 32'(urc_exp));
        end

        // R7 bounded pointer range
        urb_lim = 6'd5;
        for (int i = 0; i < 9; i++) begin
            lookup(32'h0000_0404, 0, 0, 0, 8'h05);
            chk("R7", "urc bounded", 32'(urc_o), 32'(urc_exp));
        end
        // R7 idle cycles leave the pointer alone
        repeat (3) @(negedge clk);
        chk("R7", "urc idle", 32'(urc_o), 32'(urc_exp));
        // R7 full range wraps after 63
        urb_lim = 6'd0;
        for (int i = 0; i < 70; i++) begin
            lookup(32'h0000_0404, 0, 0, 0, 8'h05);
            chk("R7", "urc full", 32'(urc_o), 32'(urc_exp));
        end
        chk("R9", "fault held", fault_addr, fault_exp);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule